// File: doc/BRIEF.md
# Twin Edge-Selectable Binary Counter

This block holds two independent 4-bit binary up-counters that share one system clock. Each counter has two count inputs and one active-high clear. One count input advances the counter on its rising edge, and the other advances it on its falling edge. When one input carries the counting clock, the other input acts as a level enable. The count inputs are treated as asynchronous signals. Each one passes through a two-flop synchroniser, and an edge is found by comparing the synchronised level with the sample taken one cycle earlier. All count state therefore changes on the system clock.

The clear is asynchronous and has priority over everything else. While it is high, the count reads zero and edges on the count inputs are lost. The chip-level reset `rst_n` is active low. It asserts asynchronously and releases through a two-stage synchroniser. When a counter steps from its top value back to zero, it raises a wrap flag for exactly one system clock cycle.

Top module: `twin_binary_counter`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it rises, every count and wrap output reads 0. Asserting `rst_n` low clears the outputs without waiting for a clock edge.
- R2: A rising edge on `up_i[c]` adds one to counter c when the synchronised level of `dn_i[c]` is high in the same sample.
- R3: A rising edge on `up_i[c]` leaves counter c unchanged when `dn_i[c]` is low in the same sample.
- R4: A falling edge on `dn_i[c]` adds one to counter c when the synchronised level of `up_i[c]` is low in the same sample.
- R5: A falling edge on `dn_i[c]` leaves counter c unchanged when `up_i[c]` is high in the same sample.
- R6: Counter c wraps from 15 to 0. `wrap_o[c]` is high in the one cycle in which the count first shows 0 after the wrap and is low in the following cycle.
- R7: Raising `clr_i[c]` forces counter c to 0 and `wrap_o[c]` to 0 at once, without a system clock edge.
- R8: Edges on `up_i[c]` or `dn_i[c]` while `clr_i[c]` is high do not count. After the clear falls, the count stays at 0 until the next qualifying edge.
- R9: The two counters are independent. Counter c is bits `[4c+3:4c]` of `cnt_o`, and stimulus or clear on one counter never changes the other.
- R10: A change on a count input shows on `cnt_o` after the third rising system clock edge that follows the change, and not after the second.
- R11: If a rising `up_i[c]` and a falling `dn_i[c]` appear in the same synchronised sample, neither is qualified and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, active low, asserts asynchronously, releases synchronously |
| clr_i | input | 2 | Per-counter asynchronous clear, active high |
| up_i | input | 2 | Per-counter input that counts on its rising edge |
| dn_i | input | 2 | Per-counter input that counts on its falling edge |
| cnt_o | output | 8 | Counts; counter c is in bits [4c+3:4c] |
| wrap_o | output | 2 | Per-counter one-cycle pulse when the count wraps to 0 |

## Verification
Two events can reach the same synchronised sample. The first pair is a rising edge on the up input and a falling edge on the down input. The second pair is a qualified edge and an active clear. The bench changes both count inputs of a counter at the same instant, so both transitions come through the synchronisers together. It expects no step, because each edge then sees the other input in its disabling level. The bench also toggles the inputs while the clear is held and expects a zero count, both during the clear and after it falls. A reference model of the enable rules computes the expected counts, and a scoreboard compares them with `cnt_o` and `wrap_o` three clock edges after each change.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned CNT_W_DEF  = 4;
  localparam int unsigned SYNC_N_DEF = 2;
  localparam int unsigned CHAN_N_DEF = 2;

  // qualified count events found in one synchronised sample
  typedef struct packed {
    logic up_hit;
    logic dn_hit;
  } tcc_evt_t;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = STAGES'({sh_q, d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tcc_edge_qual.sv
module tcc_edge_qual
  import tcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_s,
  input  logic     dn_s,
  output tcc_evt_t evt
);
  logic up_prev_q, dn_prev_q;

  // each edge is gated by the current level of the opposite input
  always_comb begin
    evt.up_hit = up_s & ~up_prev_q & dn_s;
    evt.dn_hit = ~dn_s & dn_prev_q & ~up_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev_q <= 1'b0;
      dn_prev_q <= 1'b0;
    end else begin
      up_prev_q <= up_s;
      dn_prev_q <= dn_s;
    end
  end
endmodule

// File: rtl/tcc_count_core.sv
module tcc_count_core #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         step,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    wrap_d = step && (cnt_q == CNT_TOP);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) wrap_q <= 1'b0;
    else         wrap_q <= wrap_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  assert_wrap_single_R6: assert property (@(posedge clk) disable iff (!arst_n)
    wrap_q |=> !wrap_q);
  assert_wrap_at_zero_R6: assert property (@(posedge clk) disable iff (!arst_n)
    wrap_q |-> (cnt_q == '0));
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(arst_n) && cnt_q != $past(cnt_q)) |-> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int unsigned W      = CNT_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         up_raw,
  input  logic         dn_raw,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam int unsigned IN_N = 2;

  logic [IN_N-1:0] raw_v, syn_v;
  tcc_evt_t        evt;
  logic            step;
  logic            core_rst_n;

  assign raw_v = {dn_raw, up_raw};

  for (genvar g = 0; g < IN_N; g++) begin : g_in_sync
    tcc_sync #(.STAGES(SYNC_N)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_v[g]),
      .q    (syn_v[g])
    );
  end

  tcc_edge_qual u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .up_s (syn_v[0]),
    .dn_s (syn_v[1]),
    .evt  (evt)
  );

  always_comb begin
    step       = evt.up_hit | evt.dn_hit;
    core_rst_n = rst_n & ~clr;
  end

  tcc_count_core #(.W(W)) u_core (
    .clk   (clk),
    .arst_n(core_rst_n),
    .step  (step),
    .cnt_o (cnt_o),
    .wrap_o(wrap_o)
  );

  assert_clear_holds_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (cnt_o == '0 && !wrap_o));
  assert_step_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (clr || cnt_o == W'($past(cnt_o) + 1'b1)));
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> (clr || $stable(cnt_o)));
endmodule

// File: rtl/twin_binary_counter.sv
module twin_binary_counter
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF,
  parameter int unsigned CHAN_N = CHAN_N_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CHAN_N-1:0]       clr_i,
  input  logic [CHAN_N-1:0]       up_i,
  input  logic [CHAN_N-1:0]       dn_i,
  output logic [CHAN_N*CNT_W-1:0] cnt_o,
  output logic [CHAN_N-1:0]       wrap_o
);
  logic rst_n_s;

  // reset asserts at once and releases after SYNC_N clock edges
  tcc_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_n_s)
  );

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    tcc_channel #(.W(CNT_W), .SYNC_N(SYNC_N)) u_chan (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (clr_i[c]),
      .up_raw(up_i[c]),
      .dn_raw(dn_i[c]),
      .cnt_o (cnt_o[c*CNT_W +: CNT_W]),
      .wrap_o(wrap_o[c])
    );
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n_s |-> (cnt_o == '0 && wrap_o == '0));
endmodule

// File: tb/twin_binary_counter_tb.sv
module twin_binary_counter_tb;
  localparam int W  = 4;
  localparam int CH = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [CH-1:0]   clr_i, up_i, dn_i;
  logic [CH*W-1:0] cnt_o;
  logic [CH-1:0]   wrap_o;

  always #4 clk = ~clk;

  twin_binary_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .up_i(up_i), .dn_i(dn_i),
    .cnt_o(cnt_o), .wrap_o(wrap_o)
  );

  typedef struct {
    string      req;
    int         ch;
    logic [W-1:0] c;
    logic       w;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_c [CH];
  logic lvl_up [CH];
  logic lvl_dn [CH];

  task automatic check(string req, int ch, logic [W-1:0] ac, logic [W-1:0] ec,
                       logic aw, logic ew);
    total++;
    if (ac !== ec || aw !== ew) begin
      bad++;
      $display("FAIL %s ch%0d cnt=%0d wrap=%0b expected cnt=%0d wrap=%0b",
               req, ch, ac, aw, ec, ew);
    end
  endtask

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, it.ch, cnt_o[it.ch*W +: W], it.c, wrap_o[it.ch], it.w);
    end
  end

  // driver: moves both inputs of one counter, models the step, queues results
  task automatic apply(int ch, logic u, logic d, string req);
    logic inc, wr;
    @(negedge clk);
    inc = ((!lvl_up[ch] && u && d) || (lvl_dn[ch] && !d && !u)) && !clr_i[ch];
    wr  = inc && (exp_c[ch] == 4'd15);
    up_i[ch] = u; dn_i[ch] = d;
    lvl_up[ch] = u; lvl_dn[ch] = d;
    if (inc) exp_c[ch] = exp_c[ch] + 1'b1;
    repeat (3) @(posedge clk);
    for (int c = 0; c < CH; c++)
      sb_q.push_back('{(c == ch) ? req : "R9", c, exp_c[c], (c == ch) ? wr : 1'b0});
    @(posedge clk);
    sb_q.push_back('{(wr ? "R6" : req), ch, exp_c[ch], 1'b0});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_i = '0; up_i = '0; dn_i = '0;
    for (int c = 0; c < CH; c++) begin
      exp_c[c] = '0; lvl_up[c] = 1'b0; lvl_dn[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < CH; c++) check("R1", c, cnt_o[c*W +: W], '0, wrap_o[c], 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < CH; c++) check("R1", c, cnt_o[c*W +: W], '0, wrap_o[c], 1'b0);

    // R2: up rising edge with down input high
    apply(0, 1'b0, 1'b1, "R4");
    apply(0, 1'b1, 1'b1, "R2");
    apply(0, 1'b0, 1'b1, "R2");
    apply(0, 1'b1, 1'b1, "R2");
    apply(0, 1'b0, 1'b1, "R2");
    // R4: down falling edge with up input low
    apply(0, 1'b0, 1'b0, "R4");
    // R3: up rising edge with down input low
    apply(0, 1'b1, 1'b0, "R3");
    // R5: down falling edge with up input high
    apply(0, 1'b1, 1'b1, "R5");
    apply(0, 1'b1, 1'b0, "R5");
    apply(0, 1'b0, 1'b0, "R3");
    // R11: simultaneous up rise and down fall
    apply(0, 1'b0, 1'b1, "R11");
    apply(0, 1'b1, 1'b0, "R11");
    apply(0, 1'b0, 1'b1, "R11");

    // R6: run past 15 so the counter wraps
    for (int i = 0; i < 16; i++) begin
      apply(0, 1'b1, 1'b1, "R6");
      apply(0, 1'b0, 1'b1, "R6");
    end

    // R10: latency of the synchroniser and edge stage
    @(negedge clk);
    up_i[0] = 1'b1; lvl_up[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", 0, cnt_o[3:0], exp_c[0], wrap_o[0], 1'b0);
    exp_c[0] = exp_c[0] + 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", 0, cnt_o[3:0], exp_c[0], wrap_o[0], 1'b0);
    apply(0, 1'b0, 1'b1, "R10");

    // R9: counter 1 counts on down falls while counter 0 stays put
    apply(1, 1'b0, 1'b1, "R9");
    apply(1, 1'b0, 1'b0, "R4");
    apply(1, 1'b0, 1'b1, "R9");
    apply(1, 1'b0, 1'b0, "R4");

    // R7: asynchronous clear of counter 0
    @(negedge clk);
    clr_i[0] = 1'b1;
    #1;
    check("R7", 0, cnt_o[3:0], '0, wrap_o[0], 1'b0);
    check("R9", 1, cnt_o[7:4], exp_c[1], wrap_o[1], 1'b0);
    exp_c[0] = '0;
    // R8: edges during the clear are lost
    apply(0, 1'b1, 1'b1, "R8");
    apply(0, 1'b0, 1'b1, "R8");
    apply(0, 1'b0, 1'b0, "R8");
    apply(0, 1'b0, 1'b1, "R8");
    @(negedge clk);
    clr_i[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", 0, cnt_o[3:0], '0, wrap_o[0], 1'b0);
    apply(0, 1'b1, 1'b1, "R8");

    // R1: chip reset clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < CH; c++) check("R1", c, cnt_o[c*W +: W], '0, wrap_o[c], 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule